// File: doc/BRIEF.md
# Per-Line Retention Expiry Monitor

This block tracks how long each line of a cache unit has been resident. The cache unit is built from volatile memory cells that hold data only for a limited time. Each line has a small counter with N states. A slow monitor tick moves every counter forward by one state. A write or an invalidate to a line sends that line's counter back to the first state. A line whose counter reaches the final state is flagged as expired.

The block never refreshes a line. An expired line is handed to the cache controller through a request: a writeback if the line is dirty, or a plain invalidation if it is clean. The controller acknowledges each request. Stale data is therefore never read, because every line is retired before its retention window runs out. N equals the retention time divided by the tick period, so a 100 µs window with a 10 µs tick gives N = 10 and a 4-bit counter.

Top module: `retention_expiry_monitor`

## Requirements
- R1: After a synchronous active-low reset, every counter is in state 0. No line is expired and `req_valid_o` is 0.
- R2: A valid line's counter moves forward one state for each rising edge of `tick_i`. A tick held high for many clock cycles counts once. Clock cycles without a tick edge leave the counter unchanged.
- R3: A write or invalidate event on a line returns its counter to state 0, whatever state it was in.
- R4: A valid line starting from state 0 shows `expired_o` high after exactly STATES-1 tick edges, and not before. It then stays in the last state, ignoring further ticks, until it is restarted or retired.
- R5: While `valid_i` of a line is 0, its counter is held at state 0 and its expiry flag is 0. When the line becomes valid again, it starts from state 0.
- R6: `req_valid_o` is 1 whenever any line is expired. `req_line_o` then gives the lowest-numbered expired line.
- R7: `req_wb_o` is 1 (writeback) when the presented line's dirty bit is 1, and 0 (invalidate only) when it is 0.
- R8: `req_ack_i` high with a request pending returns the presented line to state 0. The next lowest expired line is presented in the following cycle.
- R9: A write to the presented line in the same cycle as its acknowledge resets the counter, and the expiry is dropped without being presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Monitor tick, synchronous to clk; each rising edge counts once |
| valid_i | input | LINES | Per-line valid status |
| dirty_i | input | LINES | Per-line dirty status |
| wr_evt_i | input | LINES | Per-line write event, one cycle per write |
| inv_evt_i | input | LINES | Per-line invalidate event |
| req_valid_o | output | 1 | An expired line awaits service |
| req_line_o | output | $clog2(LINES) | Index of the presented expired line |
| req_wb_o | output | 1 | 1 = write back then retire, 0 = invalidate only |
| req_ack_i | input | 1 | Controller has serviced the presented line |
| expired_o | output | LINES | Per-line expired flag |

## Verification
The hardest case to reach is several lines expiring together while the controller is acknowledging them one by one. Under those conditions, a write can hit the line being acknowledged in the same cycle, and a line can drop its valid bit while it waits. The bench brings every line to the last state with a tick sequence that includes one long-held tick. It then retires the lines in turn, mixing in a write that coincides with an acknowledge, a plain write, an invalidate and a valid drop, so that the presented index steps through a known order. A long pseudo-random run then mixes ticks, events, valid drops and acknowledges on a small configuration. A reference model in the bench, built from the requirements, predicts every output in every cycle.

// File: rtl/retx_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the retention expiry monitor.
// Assumes: nothing beyond standard SystemVerilog.
package retx_pkg;
    // Kind of service asked of the cache controller for an expired line.
    typedef enum logic {
        SVC_INVALIDATE = 1'b0,
        SVC_WRITEBACK  = 1'b1
    } svc_kind_e;
endpackage

// File: rtl/retx_tick_edge.sv
`timescale 1ns/1ps
// Module: retx_tick_edge
// Turns the level monitor tick into a single-cycle advance pulse on its
// rising edge, so a tick held high for many clocks counts once.
// Assumes: tick_i is already synchronous to clk.
module retx_tick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic rise_o
);
    logic tick_q;

    // Remember last cycle's tick level.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_i;
    end

    // Pulse when the tick is high now but was low before.
    always_comb rise_o = tick_i && !tick_q;

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/retx_line_counter.sv
`timescale 1ns/1ps
// Module: retx_line_counter
// Retention age counter for one cache line. Moves from state 0 to state
// STATES-1 by one step per advance pulse and saturates there. Any restart
// (write or invalidate), retirement (acknowledged expiry) or an invalid
// line forces state 0. Expiry is reported while valid and saturated.
// Assumes: STATES >= 2; adv_i is a single-cycle pulse.
module retx_line_counter #(
    parameter int STATES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic valid_i,
    input  logic restart_i,
    input  logic retire_i,
    output logic expired_o
);
    localparam int CW = (STATES > 2) ? $clog2(STATES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STATES - 1);

    logic [CW-1:0] cnt_q;
    logic          clear;

    // Any reason that sends the line back to state 0.
    always_comb clear = !valid_i || restart_i || retire_i;

    // Age the line, saturating at the last state.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (clear)                cnt_q <= '0;
        else if (adv_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    // Flag expiry only for a resident line in its final state.
    always_comb expired_o = valid_i && (cnt_q == LAST);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_hold_at_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !restart_i && !retire_i) |=> (cnt_q == LAST));
    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
    p_invalid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (cnt_q == '0));
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clear) |=> $stable(cnt_q));
    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/retx_lowest_pick.sv
`timescale 1ns/1ps
// Module: retx_lowest_pick
// Fixed-priority selector: finds the lowest-numbered asserted request and
// returns its index plus a one-hot grant.
// Assumes: LINES >= 2; clk and rst_n serve only the checks below.
module retx_lowest_pick #(
    parameter int LINES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINES-1:0]         req_i,
    output logic                     any_o,
    output logic [$clog2(LINES)-1:0] idx_o,
    output logic [LINES-1:0]         grant_o
);
    localparam int IW = $clog2(LINES);

    // Scan from the top so the lowest asserted index wins last.
    always_comb begin
        idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
        any_o   = |req_i;
        grant_o = any_o ? (LINES'(1) << idx_o) : '0;
    end

    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    p_pick_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);
    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((req_i & ((LINES'(1) << idx_o) - LINES'(1))) == '0));
endmodule

// File: rtl/retention_expiry_monitor.sv
`timescale 1ns/1ps
// Module: retention_expiry_monitor
// One retention age counter per cache line, advanced by the monitor tick.
// Expired lines are presented to the cache controller one at a time,
// lowest index first, as writeback (dirty) or invalidate (clean) requests.
// An acknowledge retires the presented line by restarting its counter.
// Assumes: the controller clears valid_i after retiring a line, LINES >= 2,
// STATES >= 2, and req_ack_i refers to the line presented in the same cycle.
module retention_expiry_monitor #(
    parameter int LINES  = 64,
    parameter int STATES = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic [LINES-1:0]         valid_i,
    input  logic [LINES-1:0]         dirty_i,
    input  logic [LINES-1:0]         wr_evt_i,
    input  logic [LINES-1:0]         inv_evt_i,
    output logic                     req_valid_o,
    output logic [$clog2(LINES)-1:0] req_line_o,
    output logic                     req_wb_o,
    input  logic                     req_ack_i,
    output logic [LINES-1:0]         expired_o
);
    import retx_pkg::*;

    logic             adv;
    logic [LINES-1:0] grant;
    svc_kind_e        kind;

    retx_tick_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .rise_o (adv)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        retx_line_counter #(.STATES(STATES)) i_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv_i     (adv),
            .valid_i   (valid_i[g]),
            .restart_i (wr_evt_i[g] || inv_evt_i[g]),
            .retire_i  (grant[g] && req_ack_i),
            .expired_o (expired_o[g])
        );
    end

    retx_lowest_pick #(.LINES(LINES)) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (expired_o),
        .any_o   (req_valid_o),
        .idx_o   (req_line_o),
        .grant_o (grant)
    );

    // Choose the service kind from the presented line's dirty bit.
    always_comb begin
        kind     = dirty_i[req_line_o] ? SVC_WRITEBACK : SVC_INVALIDATE;
        req_wb_o = req_valid_o && (kind == SVC_WRITEBACK);
    end

    p_ack_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ack_i) |=> !expired_o[$past(req_line_o)]);
    p_req_iff_expired_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o == (expired_o != '0));
    p_no_expiry_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (expired_o == '0));
endmodule

// File: tb/test_retention_expiry_monitor.sv
`timescale 1ns/1ps
module test_retention_expiry_monitor;
    localparam int LINES  = 8;
    localparam int STATES = 4;
    localparam int LASTS  = STATES - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] valid = '0, dirty = '0, wr = '0, inv = '0;
    logic       ack = 1'b0;
    logic       req_valid, req_wb;
    logic [2:0] req_line;
    logic [7:0] expired;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int mcnt [LINES];
    bit mtickq = 0;

    always #2.5 clk = ~clk;

    retention_expiry_monitor #(.LINES(LINES), .STATES(STATES)) i_retention_expiry_monitor (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .valid_i(valid), .dirty_i(dirty),
        .wr_evt_i(wr), .inv_evt_i(inv), .req_valid_o(req_valid), .req_line_o(req_line),
        .req_wb_o(req_wb), .req_ack_i(ack), .expired_o(expired)
    );

    function automatic logic [7:0] m_expired();
        logic [7:0] e = '0;
        for (int i = 0; i < LINES; i++) e[i] = valid[i] && (mcnt[i] == LASTS);
        return e;
    endfunction

    function automatic int m_lowest(input logic [7:0] e);
        for (int i = 0; i < LINES; i++) if (e[i]) return i;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: update the model from current inputs, then sample past the edge.
    task automatic step();
        logic [7:0] e;
        bit rise;
        int pres;
        e = m_expired();
        pres = m_lowest(e);
        rise = tick && !mtickq;
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n || !valid[i] || wr[i] || inv[i] || (ack && e != 0 && i == pres))
                mcnt[i] = 0;
            else if (rise && mcnt[i] < LASTS)
                mcnt[i] = mcnt[i] + 1;
        end
        mtickq = rst_n ? tick : 1'b0;
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic compare();
        logic [7:0] e;
        e = m_expired();
        check(expired == e, "R4 expired flags", expired, e);
        check(req_valid == (e != 0), "R6 request valid", req_valid, e != 0);
        if (e != 0) begin
            check(req_line == 3'(m_lowest(e)), "R6 lowest index", req_line, m_lowest(e));
            check(req_wb == dirty[m_lowest(e)], "R7 writeback select", req_wb, dirty[m_lowest(e)]);
        end
    endtask

    task automatic tick_pulse(input int hold);
        tick = 1'b1;
        for (int k = 0; k < hold; k++) step();
        tick = 1'b0;
        step();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) mcnt[i] = 0;
        for (int k = 0; k < 3; k++) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check(expired == 8'h00, "R1 no expiry after reset", expired, 0);
        check(req_valid == 1'b0, "R1 no request after reset", req_valid, 0);

        valid = 8'hFF;
        dirty = 8'hA5;
        step();
        // R2: a long-held tick counts once
        tick_pulse(5);
        check(expired == 8'h00, "R2 held tick counts once", expired, 0);
        tick_pulse(1);
        check(expired == 8'h00, "R4 not expired before last state", expired, 0);
        tick_pulse(1);
        check(expired == 8'hFF, "R4 expired after STATES-1 edges", expired, 8'hFF);
        check(req_valid && req_line == 3'd0, "R6 line 0 first", req_line, 0);
        check(req_wb == 1'b1, "R7 dirty line asks writeback", req_wb, 1);
        tick_pulse(2);
        check(expired == 8'hFF, "R4 saturates at last state", expired, 8'hFF);

        // R8: acknowledge retires the presented line
        ack = 1'b1; step(); ack = 1'b0;
        check(expired == 8'hFE, "R8 ack retires line 0", expired, 8'hFE);
        check(req_line == 3'd1, "R8 next line presented", req_line, 1);
        check(req_wb == 1'b0, "R7 clean line asks invalidate", req_wb, 0);

        // R9: write coincides with acknowledge
        wr = 8'h02; ack = 1'b1; step(); wr = '0; ack = 1'b0;
        check(expired == 8'hFC, "R9 write with ack drops expiry", expired, 8'hFC);
        check(req_line == 3'd2, "R9 next line after dropped", req_line, 2);

        // R3: write and invalidate restart a line
        wr = 8'h20; step(); wr = '0;
        check(expired == 8'hDC, "R3 write restarts line 5", expired, 8'hDC);
        inv = 8'h08; step(); inv = '0;
        check(expired == 8'hD4, "R3 invalidate restarts line 3", expired, 8'hD4);

        // R5: invalid line held at state 0
        valid = 8'hFB; step();
        check(expired == 8'hD0, "R5 invalid line not expired", expired, 8'hD0);
        valid = 8'hFF; step();
        check(expired == 8'hD0, "R5 revalidated line restarts", expired, 8'hD0);
        check(req_line == 3'd4 && req_wb == 1'b0, "R6 line 4 presented clean", req_line, 4);
        tick_pulse(1); tick_pulse(1);
        check(expired == 8'hD0, "R5 line 2 two edges short", expired, 8'hD0);
        tick_pulse(1);
        check(expired == 8'hFF, "R4 restarted lines expire again", expired, 8'hFF);

        // Sweep: pseudo-random mix checked against the model every cycle
        for (int c = 0; c < 4000; c++) begin
            valid = ~(8'(1) << ($urandom % 16));
            dirty = 8'($urandom);
            wr    = ($urandom % 6 == 0) ? (8'(1) << ($urandom % 8)) : 8'h00;
            inv   = ($urandom % 9 == 0) ? (8'(1) << ($urandom % 8)) : 8'h00;
            tick  = ($urandom % 3 == 0);
            ack   = ($urandom % 3 == 0);
            if (c % 997 == 500) rst_n = 1'b0; else rst_n = 1'b1;
            step();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule